// File: doc/BRIEF.md
# Software Power-Down and Wake Controller

This block manages the system power-enable pin and the interrupt pin of a battery-backed timekeeping device. Both pins are open-drain. The block drives each one with an output-enable, and the pad pulls the line low while that enable is high.

Software turns the system off by setting a sleep bit in a small control register. The power-enable drive is then released. Two event sources can turn the system back on: a wake-up event from the alarm logic and a kickstart push-button. Each source has a sticky flag and an enable bit. A new event on an enabled source whose flag is clear drives the power-enable pin again. The same event also clears the sleep bit.

The power-fail comparator is modelled as a digital input. While the supply is below the threshold, register writes are locked out and the interrupt drive is released. Event monitoring carries on throughout.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, `pwr_en_oe` is 1, `irq_oe` is 0 and `rd_data` is 0.
- R2: A write with bit 0 (sleep) set, while `supply_ok` is high, makes `pwr_en_oe` 0 from the next cycle. This holds unless a qualifying event lands in that cycle.
- R3: A rising edge on `wake_in` sets the wake flag (bit 3). A debounced kickstart press sets the kick flag (bit 4). Both flags are set whether or not the matching enable is set.
- R4: A qualifying event drives `pwr_en_oe` to 1 and clears the sleep bit. An event qualifies when it is a wake event with the wake enable (bit 1) set and the wake flag clear, or a kick event with the kick enable (bit 2) set and the kick flag clear. This holds even when the supply is already present.
- R5: An event whose enable is clear, or whose flag is already set, leaves `pwr_en_oe` released.
- R6: Writing 0 to a flag bit clears that flag. Writing 1 to it leaves the flag unchanged.
- R7: `irq_oe` is 1 exactly when `supply_ok` is high and an enabled flag is set (wake flag with wake enable, or kick flag with kick enable).
- R8: While `supply_ok` is low, writes have no effect on the register.
- R9: While asleep with `supply_ok` low, both output-enables are 0. Events are still detected and still reassert power.
- R10: A kickstart level shorter than DEB_CYCLES samples produces no event. A held press produces exactly one event, and its release produces none.
- R11: If a sleep write and a qualifying event fall in the same cycle, the event wins: the sleep bit ends up 0 and `pwr_en_oe` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | High while the supply is above the power-fail threshold |
| wake_in | input | 1 | Wake-up request from the alarm logic (rising edge) |
| kick_in | input | 1 | Raw kickstart button (polarity set by KICK_ACTIVE_LOW) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data: 0 sleep, 1 wake enable, 2 kick enable, 3 wake flag, 4 kick flag |
| rd_data | output | 5 | Current register contents, same layout |
| pwr_en_oe | output | 1 | Drive enable of the open-drain power-enable pin |
| irq_oe | output | 1 | Drive enable of the open-drain interrupt pin |

## Verification
A software sleep write and a qualifying wake event can both update the sleep bit in the same clock cycle. To provoke this, the bench raises `wake_in` and counts the synchronizer and edge-register stages. It then holds the sleep write across exactly the edge on which the wake pulse reaches the register. The result is judged by reading back a sleep bit of 0 and a power drive that stays on. A second overlap is tested too: a flag-clearing write issued while the kickstart button is still held must not lead to a second event.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
   localparam int REG_W      = 5;
   localparam int B_SLEEP    = 0;
   localparam int B_WAKE_EN  = 1;
   localparam int B_KICK_EN  = 2;
   localparam int B_WAKE_FLG = 3;
   localparam int B_KICK_FLG = 4;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwd_event.sv
module pwd_event #(
   parameter int SYNC_STAGES  = 2,
   parameter bit USE_DEBOUNCE = 1'b0,
   parameter int DEB_CYCLES   = 16,
   parameter bit ACTIVE_LOW   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic pulse
);
   if (USE_DEBOUNCE && DEB_CYCLES < 2) begin : g_bad_deb
      $error("pwd_event: DEB_CYCLES must be at least 2");
   end

   logic level_in;
   logic s;

   if (ACTIVE_LOW) begin : g_inv
      assign level_in = ~raw;
   end else begin : g_pass
      assign level_in = raw;
   end

   pwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(level_in), .q(s)
   );

   if (USE_DEBOUNCE) begin : g_deb
      localparam int CW = $clog2(DEB_CYCLES);
      logic [CW-1:0] cnt;
      logic          stable;
      logic          pulse_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            stable  <= 1'b0;
            pulse_q <= 1'b0;
         end else if (s != stable) begin
            if (cnt == CW'(DEB_CYCLES - 1)) begin
               stable  <= s;
               cnt     <= '0;
               pulse_q <= s;
            end else begin
               cnt     <= cnt + 1'b1;
               pulse_q <= 1'b0;
            end
         end else begin
            cnt     <= '0;
            pulse_q <= 1'b0;
         end
      end
      assign pulse = pulse_q;
   end else begin : g_edge
      logic prev;
      logic pulse_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev    <= 1'b0;
            pulse_q <= 1'b0;
         end else begin
            prev    <= s;
            pulse_q <= s & ~prev;
         end
      end
      assign pulse = pulse_q;
   end
endmodule

// File: rtl/pwd_regs.sv
module pwd_regs
   import pwd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             wake_pulse,
   input  logic             kick_pulse,
   output logic [REG_W-1:0] regs
);
   logic [REG_W-1:0] nxt;
   logic             wr_ok;
   logic             wake_qual;
   logic             kick_qual;

   assign wr_ok     = wr_en & supply_ok;
   assign wake_qual = wake_pulse & regs[B_WAKE_EN] & ~regs[B_WAKE_FLG];
   assign kick_qual = kick_pulse & regs[B_KICK_EN] & ~regs[B_KICK_FLG];

   always_comb begin
      nxt = regs;
      if (wr_ok) begin
         nxt[B_SLEEP]   = wr_data[B_SLEEP];
         nxt[B_WAKE_EN] = wr_data[B_WAKE_EN];
         nxt[B_KICK_EN] = wr_data[B_KICK_EN];
         if (!wr_data[B_WAKE_FLG]) nxt[B_WAKE_FLG] = 1'b0;
         if (!wr_data[B_KICK_FLG]) nxt[B_KICK_FLG] = 1'b0;
      end
      if (wake_pulse) nxt[B_WAKE_FLG] = 1'b1;
      if (kick_pulse) nxt[B_KICK_FLG] = 1'b1;
      if (wake_qual || kick_qual) nxt[B_SLEEP] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs <= '0;
      else        regs <= nxt;
   end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwd_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEB_CYCLES      = 16,
   parameter bit KICK_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             wake_in,
   input  logic             kick_in,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             pwr_en_oe,
   output logic             irq_oe
);
   logic             wake_pulse;
   logic             kick_pulse;
   logic [REG_W-1:0] regs;
   logic             pending;

   pwd_event #(
      .SYNC_STAGES(SYNC_STAGES), .USE_DEBOUNCE(1'b0),
      .DEB_CYCLES(DEB_CYCLES), .ACTIVE_LOW(1'b0)
   ) u_wake (
      .clk(clk), .rst_n(rst_n), .raw(wake_in), .pulse(wake_pulse)
   );

   pwd_event #(
      .SYNC_STAGES(SYNC_STAGES), .USE_DEBOUNCE(1'b1),
      .DEB_CYCLES(DEB_CYCLES), .ACTIVE_LOW(KICK_ACTIVE_LOW)
   ) u_kick (
      .clk(clk), .rst_n(rst_n), .raw(kick_in), .pulse(kick_pulse)
   );

   pwd_regs u_regs (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .wr_en(wr_en), .wr_data(wr_data),
      .wake_pulse(wake_pulse), .kick_pulse(kick_pulse),
      .regs(regs)
   );

   assign pending   = (regs[B_WAKE_FLG] & regs[B_WAKE_EN]) |
                      (regs[B_KICK_FLG] & regs[B_KICK_EN]);
   assign pwr_en_oe = ~regs[B_SLEEP];
   assign irq_oe    = supply_ok & pending;
   assign rd_data   = regs;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       wr_en,
   input logic       wr_sleep,
   input logic       wr_wflg,
   input logic [4:0] rd_data,
   input logic       pwr_en_oe,
   input logic       irq_oe,
   input logic       wake_pulse,
   input logic       kick_pulse
);
   // R2
   sleep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && wr_en && wr_sleep && !wake_pulse && !kick_pulse) |=> !pwr_en_oe);

   // R3
   wake_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> rd_data[3]);

   // R4
   wake_repower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && rd_data[1] && !rd_data[3]) |=> pwr_en_oe);

   // R6
   wake_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[3] && !(wr_en && supply_ok && !wr_wflg)) |=> rd_data[3]);

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |-> !irq_oe);

   // R8
   write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok && wr_en) |=> (rd_data[2:1] == $past(rd_data[2:1])));

   // R10
   kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_pulse |=> !kick_pulse);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_en(wr_en),
   .wr_sleep(wr_data[0]), .wr_wflg(wr_data[3]), .rd_data(rd_data),
   .pwr_en_oe(pwr_en_oe), .irq_oe(irq_oe),
   .wake_pulse(wake_pulse), .kick_pulse(kick_pulse)
);

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
   localparam int SYNC = 2;
   localparam int DEB  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b1;
   logic       wake_in = 1'b0;
   logic       kick_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_data = '0;
   logic [4:0] rd_data;
   logic       pwr_en_oe;
   logic       irq_oe;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   pwr_wake_ctrl #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .KICK_ACTIVE_LOW(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wake_in(wake_in),
      .kick_in(kick_in), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pwr_en_oe(pwr_en_oe), .irq_oe(irq_oe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [4:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wake_event();
      @(negedge clk); wake_in = 1'b1;
      repeat (3) @(negedge clk);
      wake_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      check(pwr_en_oe == 1'b1, "R1 pwr", pwr_en_oe, 1);
      check(irq_oe == 1'b0, "R1 irq", irq_oe, 0);
      check(rd_data == 5'h00, "R1 reg", rd_data, 0);
   endtask

   task automatic t_sleep();
      write_reg(5'h01);
      check(pwr_en_oe == 1'b0, "R2 sleep releases pwr", pwr_en_oe, 0);
      check(rd_data == 5'h01, "R2 sleep bit", rd_data, 5'h01);
      write_reg(5'h00);
   endtask

   task automatic t_wake_repower();
      write_reg(5'h03);
      check(pwr_en_oe == 1'b0, "R2 asleep", pwr_en_oe, 0);
      wake_event();
      check(pwr_en_oe == 1'b1, "R4 wake repower", pwr_en_oe, 1);
      check(rd_data == 5'h0A, "R3 R4 wake flag set sleep cleared", rd_data, 5'h0A);
      check(irq_oe == 1'b1, "R7 irq pending", irq_oe, 1);
      write_reg(5'h0A);
      check(rd_data == 5'h0A, "R6 write 1 keeps flag", rd_data, 5'h0A);
      write_reg(5'h02);
      check(rd_data == 5'h02, "R6 write 0 clears flag", rd_data, 5'h02);
      check(irq_oe == 1'b0, "R7 irq released", irq_oe, 0);
      write_reg(5'h00);
   endtask

   task automatic t_no_repower();
      write_reg(5'h01);
      wake_event();
      check(rd_data == 5'h09, "R3 flag set without enable", rd_data, 5'h09);
      check(pwr_en_oe == 1'b0, "R5 disabled event", pwr_en_oe, 0);
      check(irq_oe == 1'b0, "R7 flag without enable", irq_oe, 0);
      write_reg(5'h0B);
      wake_event();
      check(pwr_en_oe == 1'b0, "R5 flag already set", pwr_en_oe, 0);
      write_reg(5'h00);
   endtask

   task automatic t_kick();
      write_reg(5'h05);
      @(negedge clk); kick_in = 1'b1;
      repeat (DEB + 8) @(negedge clk);
      check(rd_data == 5'h14, "R3 R4 kick flag and repower", rd_data, 5'h14);
      check(pwr_en_oe == 1'b1, "R4 kick repower", pwr_en_oe, 1);
      write_reg(5'h04);
      repeat (DEB + 12) @(negedge clk);
      check(rd_data == 5'h04, "R10 one event per press", rd_data, 5'h04);
      kick_in = 1'b0;
      repeat (DEB + 12) @(negedge clk);
      check(rd_data == 5'h04, "R10 no event on release", rd_data, 5'h04);
      kick_in = 1'b1;
      repeat (DEB - 2) @(negedge clk);
      kick_in = 1'b0;
      repeat (DEB + 12) @(negedge clk);
      check(rd_data == 5'h04, "R10 short press ignored", rd_data, 5'h04);
      write_reg(5'h00);
   endtask

   task automatic t_supply_low();
      write_reg(5'h03);
      @(negedge clk); supply_ok = 1'b0;
      @(negedge clk);
      check(pwr_en_oe == 1'b0 && irq_oe == 1'b0, "R9 both tri-stated",
            {pwr_en_oe, irq_oe}, 0);
      write_reg(5'h00);
      check(rd_data == 5'h03, "R8 write ignored", rd_data, 5'h03);
      wake_event();
      check(rd_data == 5'h0A, "R9 wake monitored", rd_data, 5'h0A);
      check(pwr_en_oe == 1'b1, "R9 repower while low", pwr_en_oe, 1);
      check(irq_oe == 1'b0, "R7 irq gated by supply", irq_oe, 0);
      @(negedge clk); supply_ok = 1'b1;
      @(negedge clk);
      check(irq_oe == 1'b1, "R7 irq after supply", irq_oe, 1);
      write_reg(5'h00);
   endtask

   task automatic t_same_cycle();
      write_reg(5'h02);
      @(negedge clk); wake_in = 1'b1;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 5'h03;
      @(negedge clk);
      wr_en = 1'b0;
      check(rd_data[0] == 1'b0, "R11 event beats sleep write", rd_data[0], 0);
      check(pwr_en_oe == 1'b1, "R11 power held", pwr_en_oe, 1);
      check(rd_data[3] == 1'b1, "R11 flag set", rd_data[3], 1);
      wake_in = 1'b0;
      repeat (4) @(negedge clk);
      write_reg(5'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sleep();
      t_wake_repower();
      t_no_repower();
      t_kick();
      t_supply_low();
      t_same_cycle();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule